// File: doc/BRIEF.md
# Optimal Firing Angle Search Engine

This block turns one mains cycle of sampled compensator-branch current into an 8-bit firing code for a thyristor-controlled reactor. Samples arrive one at a time on a valid strobe, 128 per mains cycle, and the first sample of each cycle is the one taken at the voltage zero crossing. The block stores each cycle in a two-bank buffer. Once the 128th sample has been accepted, it folds the cycle's symmetric quarter-wave samples into 32 signed terms and accumulates them. At each step it compares the running sum with an entry from a threshold table, and that table is loaded beforehand through a write port.

The search ends at the first step where the difference between the sum and the table entry changes sign. The code is the step index in its upper five bits and a three-bit linear interpolation between the two differences on either side of the crossing. When the difference never changes sign, a fallback applies. If the first difference exceeds a programmable level, the reactor is held off with code 255. Otherwise it conducts fully with code 0. While a search runs, the samples of the following cycle go into the other bank. The result appears well inside the quarter cycle that follows the last sample.

Top module: `fa_angle_search`

## Requirements
- R1: After reset the first accepted sample has index 0. Each group of 128 accepted samples (index 0..127) forms one cycle, and accepting index 127 starts a search over that cycle.
- R2: Fold term i (0..31) is S[(i+32)] + S[(96−i)] − S[(i+96)] − S[(32−i)], with every index taken modulo 128.
- R3: Step k (0..31) adds fold term k to a 40-bit signed running sum R_k and forms D_k = R_k − T[8k], where T is the 32-bit signed table. Table addresses that are not multiples of 8 have no effect on the result.
- R4: A sign is negative when D < 0 and non-negative otherwise. At the first k ≥ 1 whose sign differs from that of D_(k−1), the code is 8·(k−1) + f, with f = min(7, floor(8·|D_(k−1)| / (|D_(k−1)| + |D_k|))).
- R5: With no sign change over steps 0..31 and D_0 strictly greater than the signed 40-bit level on idle_thresh, the code is 255.
- R6: With no sign change and D_0 not greater than idle_thresh, the code is 0.
- R7: fire_vld is a one-cycle pulse that comes with a new fire_code. fire_code keeps its value between pulses.
- R8: fire_vld is high after the (k+1)-th rising edge that follows the edge accepting sample 127. Here k is the deciding step: the crossing step, or 31 when there is none. The result therefore takes at most 32 edges.
- R9: Samples accepted while a search runs are written to the other bank and do not change that search's result.
- R10: During and just after reset, fire_vld is 0 and fire_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed current sample |
| tbl_we | input | 1 | Threshold table write enable |
| tbl_addr | input | 8 | Threshold table write address |
| tbl_data | input | 32 | Signed threshold table write data |
| idle_thresh | input | 40 | Signed level for the no-crossing fallback decision |
| fire_code | output | 8 | Firing code, 0 = full conduction, 255 = none |
| fire_vld | output | 1 | One-cycle result strobe |

## Verification
An error in the fold index arithmetic or the bank select corrupts the running sums. That error shows up in the same cycle's result as a crossing at the wrong step or a wrong fallback code. A wrong step counter or a wrong table stride moves the crossing, and it also changes how many edges pass before fire_vld arrives, so the bench measures the exact latency as well as the code. A wrong interpolation magnitude shows only in the low three bits of the code, so the directed cases place a zero-valued difference on each side of a crossing to drive the fraction to its extremes.

// File: rtl/fa_pkg.sv
// Shared constants for the firing angle search engine.
// Assumes a power-of-two sample count divisible by four.
package fa_pkg;
    parameter int SMP_W  = 16;            // sample width
    parameter int N_SMP  = 128;           // samples per mains cycle
    parameter int TBL_W  = 32;            // threshold table word width
    parameter int ACC_W  = 40;            // running sum width
    parameter int CODE_W = 8;             // firing code width
    localparam int N_FOLD = N_SMP / 4;    // fold terms / search steps
    localparam int IDX_W  = $clog2(N_SMP);
    localparam int STEP_W = $clog2(N_FOLD);
    localparam int FRAC_W = CODE_W - STEP_W;
    localparam int TA_W   = CODE_W;       // table address width
    localparam int N_TBL  = 1 << TA_W;
    localparam int FV_W   = SMP_W + 2;    // fold term width
    localparam int DIF_W  = ACC_W + 1;    // difference width
endpackage

// File: rtl/fa_sample_buf.sv
// Two-bank sample store with cycle counter and quarter-wave fold.
// Writes go to wr_bank; the fold reads bank rd_bank at term fold_idx.
// Assumes the consumer never reads the bank currently being filled.
module fa_sample_buf
    import fa_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [SMP_W-1:0]  in_data,
    input  logic                     rd_bank,
    input  logic [STEP_W-1:0]        fold_idx,
    output logic signed [FV_W-1:0]   fold_val,
    output logic                     wr_bank,
    output logic                     cyc_done
);
    localparam logic [IDX_W-1:0] QTR  = IDX_W'(N_SMP / 4);
    localparam logic [IDX_W-1:0] QTR3 = IDX_W'(3 * (N_SMP / 4));
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SMP - 1);

    logic signed [SMP_W-1:0] mem_q [2][N_SMP];
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] ix, ia, ib, ic, id;
    logic signed [FV_W-1:0] va, vb, vc, vd;

    assign cyc_done = in_vld && (cnt_q == LAST);

    // Store each accepted sample in the bank being filled.
    always_ff @(posedge clk) begin
        if (in_vld) mem_q[wr_bank][cnt_q] <= in_data;
    end

    // Track sample index and swap banks when a cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            wr_bank <= 1'b0;
        end else if (in_vld) begin
            cnt_q <= cnt_q + IDX_W'(1);
            if (cnt_q == LAST) wr_bank <= ~wr_bank;
        end
    end

    // Form one fold term from four modulo-indexed samples.
    always_comb begin
        ix = IDX_W'(fold_idx);
        ia = ix + QTR;
        ib = QTR3 - ix;
        ic = ix + QTR3;
        id = QTR - ix;
        va = mem_q[rd_bank][ia];
        vb = mem_q[rd_bank][ib];
        vc = mem_q[rd_bank][ic];
        vd = mem_q[rd_bank][id];
        fold_val = va + vb - vc - vd;
    end
endmodule

// File: rtl/fa_thresh_table.sv
// Threshold table: synchronous write port, combinational read port.
// Assumes the table is written only while no search is running.
module fa_thresh_table
    import fa_pkg::*;
(
    input  logic                     clk,
    input  logic                     we,
    input  logic [TA_W-1:0]          waddr,
    input  logic signed [TBL_W-1:0]  wdata,
    input  logic [TA_W-1:0]          raddr,
    output logic signed [TBL_W-1:0]  rdata
);
    logic signed [TBL_W-1:0] tbl_q [N_TBL];

    // Write one table word.
    always_ff @(posedge clk) begin
        if (we) tbl_q[waddr] <= wdata;
    end

    assign rdata = tbl_q[raddr];
endmodule

// File: rtl/fa_interp.sv
// Linear interpolation between two differences of opposite sign.
// frac = min(2^FRAC_W-1, floor(2^FRAC_W*|p| / (|p|+|c|))), built from
// a bank of compare-against-multiple slots. Assumes |p|+|c| > 0.
module fa_interp
    import fa_pkg::*;
(
    input  logic signed [DIF_W-1:0]  d_prev,
    input  logic signed [DIF_W-1:0]  d_cur,
    output logic [FRAC_W-1:0]        frac
);
    localparam int NSLOT = (1 << FRAC_W) - 1;
    localparam int PW    = DIF_W + FRAC_W + 1;

    logic [DIF_W-1:0] mag_p, mag_c;
    logic [DIF_W:0]   mag_s;
    logic [PW-1:0]    lhs;
    logic [NSLOT-1:0] hit;

    // Magnitudes and their sum.
    always_comb begin
        mag_p = d_prev[DIF_W-1] ? DIF_W'(-d_prev) : DIF_W'(d_prev);
        mag_c = d_cur[DIF_W-1]  ? DIF_W'(-d_cur)  : DIF_W'(d_cur);
        mag_s = {1'b0, mag_p} + {1'b0, mag_c};
        lhs   = PW'(mag_p) << FRAC_W;
    end

    for (genvar j = 1; j <= NSLOT; j++) begin : g_slot
        assign hit[j-1] = lhs >= (PW'(mag_s) * PW'(j));
    end

    assign frac = FRAC_W'($countones(hit));
endmodule

// File: rtl/fa_angle_search.sv
// Top: one search per mains cycle over the folded samples, one step per
// clock, stopping at the first sign change of running sum minus table.
// Assumes the table and idle_thresh are stable while a search runs.
module fa_angle_search
    import fa_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [SMP_W-1:0]  smp_data,
    input  logic                     tbl_we,
    input  logic [TA_W-1:0]          tbl_addr,
    input  logic signed [TBL_W-1:0]  tbl_data,
    input  logic signed [ACC_W-1:0]  idle_thresh,
    output logic [CODE_W-1:0]        fire_code,
    output logic                     fire_vld
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_FOLD - 1);

    logic                     cyc_done, wr_bank, rd_bank, busy;
    logic [STEP_W-1:0]        step;
    logic signed [FV_W-1:0]   fold_val;
    logic signed [TBL_W-1:0]  tbl_rd;
    logic signed [ACC_W-1:0]  acc, acc_nx, fold_x;
    logic signed [DIF_W-1:0]  diff, d_prev, d_first, thr_x, tbl_x;
    logic [FRAC_W-1:0]        frac;
    logic                     flip;

    fa_sample_buf u_buf (
        .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .in_data(smp_data),
        .rd_bank(rd_bank), .fold_idx(step), .fold_val(fold_val),
        .wr_bank(wr_bank), .cyc_done(cyc_done)
    );

    fa_thresh_table u_tbl (
        .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
        .raddr({step, FRAC_W'(0)}), .rdata(tbl_rd)
    );

    fa_interp u_interp (.d_prev(d_prev), .d_cur(diff), .frac(frac));

    // Next running sum, its distance to the table, and the sign test.
    always_comb begin
        fold_x = fold_val;
        tbl_x  = tbl_rd;
        thr_x  = idle_thresh;
        acc_nx = acc + fold_x;
        diff   = DIF_W'(acc_nx) - tbl_x;
        flip   = (step != '0) && (diff[DIF_W-1] != d_prev[DIF_W-1]);
    end

    // Search sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            rd_bank   <= 1'b0;
            step      <= '0;
            acc       <= '0;
            d_prev    <= '0;
            d_first   <= '0;
            fire_code <= '0;
            fire_vld  <= 1'b0;
        end else begin
            fire_vld <= 1'b0;
            if (cyc_done) begin
                busy    <= 1'b1;
                rd_bank <= wr_bank;
                step    <= '0;
                acc     <= '0;
            end else if (busy) begin
                acc    <= acc_nx;
                d_prev <= diff;
                step   <= step + STEP_W'(1);
                if (step == '0) d_first <= diff;
                if (flip) begin
                    busy      <= 1'b0;
                    fire_vld  <= 1'b1;
                    fire_code <= {step - STEP_W'(1), frac};
                end else if (step == LAST_STEP) begin
                    busy      <= 1'b0;
                    fire_vld  <= 1'b1;
                    fire_code <= (d_first > thr_x) ? {CODE_W{1'b1}} : '0;
                end
            end
        end
    end
endmodule

// File: rtl/fa_angle_search_chk.sv
// Temporal checks on the search engine, bound into the top module.
module fa_angle_search_chk
    import fa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fire_vld,
    input logic [CODE_W-1:0] fire_code,
    input logic              busy,
    input logic              cyc_done,
    input logic              rd_bank,
    input logic              wr_bank
);
    logic [STEP_W:0] lat;

    // Count cycles spent in the current search.
    always_ff @(posedge clk) begin
        if (!rst_n || cyc_done || !busy) lat <= '0;
        else lat <= lat + (STEP_W+1)'(1);
    end

    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_vld |=> !fire_vld);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_vld |-> $stable(fire_code));
    assert_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_bank != wr_bank));
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat < (STEP_W+1)'(N_FOLD)));
    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> busy);
endmodule

bind fa_angle_search fa_angle_search_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fire_vld(fire_vld), .fire_code(fire_code),
    .busy(busy), .cyc_done(cyc_done), .rd_bank(rd_bank), .wr_bank(wr_bank)
);

// File: tb/fa_angle_search_bench.sv
`timescale 1ns/1ps
// Bench: random samples with tables shaped to put the sign change at a
// chosen step, plus directed fallback and interpolation-extreme cases.
module fa_angle_search_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic tbl_we = 1'b0;
    logic [7:0] tbl_addr = '0;
    logic signed [31:0] tbl_data = '0;
    logic signed [39:0] idle_thresh = '0;
    logic [7:0] fire_code;
    logic fire_vld;

    fa_angle_search u_fa_angle_search (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .idle_thresh(idle_thresh), .fire_code(fire_code), .fire_vld(fire_vld)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int smp [2][128];
    longint dref [32];
    int got_code, got_lat;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint fold(input int b, input int i);
        return longint'(smp[b][(i+32)%128]) + longint'(smp[b][(96-i+128)%128])
             - longint'(smp[b][(i+96)%128]) - longint'(smp[b][(32-i+128)%128]);
    endfunction

    // Expected code and deciding step from the difference list (R4, R5, R6).
    task automatic expect_code(input longint thr, output int code, output int kdec);
        code = -1;
        kdec = 31;
        for (int k = 1; k < 32; k++) begin
            if (code < 0 && ((dref[k] < 0) != (dref[k-1] < 0))) begin
                longint a = (dref[k-1] < 0) ? -dref[k-1] : dref[k-1];
                longint b = (dref[k] < 0) ? -dref[k] : dref[k];
                longint f = (8 * a) / (a + b);
                if (f > 7) f = 7;
                code = 8 * (k - 1) + int'(f);
                kdec = k;
            end
        end
        if (code < 0) code = (dref[0] > thr) ? 255 : 0;
    endtask

    // Build and load a table putting the first sign change at step c (0 = none).
    task automatic load_table(input int b, input int c, input bit pol, input int special);
        longint r = 0;
        longint tv [32];
        for (int k = 0; k < 32; k++) begin
            longint o = longint'($urandom_range(1, 4000));
            bit neg;
            r += fold(b, k);
            if (c == 0 || k < c) neg = !pol;
            else if (k == c) neg = pol;
            else neg = bit'($urandom_range(0, 1));
            if (special == 1 && k == c - 1) o = 0;
            if (special == 2 && k == c) o = 0;
            dref[k] = neg ? -o : o;
            tv[k] = r - dref[k];
        end
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            tbl_we = 1'b1;
            tbl_addr = 8'(a);
            tbl_data = (a % 8 == 0) ? 32'(tv[a/8]) : 32'($urandom);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic gen(input int b);
        for (int i = 0; i < 128; i++) smp[b][i] = int'($urandom_range(0, 65535)) - 32768;
    endtask

    task automatic send(input int b, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 7) == 0) begin
                smp_vld = 1'b0;
                @(negedge clk);
            end
            smp_vld = 1'b1;
            smp_data = 16'(smp[b][i]);
        end
    endtask

    task automatic wait_result();
        int cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!fire_vld && cnt < 100);
        got_lat = cnt;
        got_code = int'(fire_code);
        @(negedge clk);
        check(!fire_vld, "R7 pulse width", longint'(fire_vld), 0);
        check(int'(fire_code) == got_code, "R7 code hold", longint'(fire_code), got_code);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int b = 0, sent = 0, exp_code, kdec;
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        check(fire_vld == 1'b0, "R10 reset valid", longint'(fire_vld), 0);
        check(fire_code == 8'd0, "R10 reset code", longint'(fire_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fire_vld == 1'b0 && fire_code == 8'd0, "R10 after reset", longint'(fire_code), 0);
        gen(0);
        for (int n = 0; n < 40; n++) begin
            int c, special = 0;
            bit pol = bit'($urandom_range(0, 1));
            case (n)
                0: c = 1;
                1: c = 31;
                2, 3: c = 0;
                4: begin c = 9; pol = 1; special = 1; end
                5: begin c = 17; pol = 0; special = 2; end
                default: c = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 31));
            endcase
            load_table(b, c, pol, special);
            // R5/R6 boundary: strictly greater than the level yields 255
            if (n == 2) idle_thresh = 40'(dref[0] - 1);
            else if (n == 3) idle_thresh = 40'(dref[0]);
            else idle_thresh = 40'(dref[0] + longint'($urandom_range(0, 20)) - 10);
            expect_code(longint'(idle_thresh), exp_code, kdec);
            send(b, sent, 127);
            gen(1 - b);
            // R9: next cycle's first half streams in during the search
            fork
                send(1 - b, 0, 63);
                wait_result();
            join
            @(negedge clk);
            smp_vld = 1'b0;
            if (c == 0)
                check(got_code == exp_code, (dref[0] > longint'(idle_thresh)) ? "R5 fallback off" : "R6 fallback full",
                      got_code, exp_code);
            else
                check(got_code == exp_code, "R4 R2 R3 R9 crossing code", got_code, exp_code);
            check(got_lat == kdec + 2, "R8 R1 latency", got_lat, kdec + 2);
            b = 1 - b;
            sent = 64;
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule